// File: doc/BRIEF.md
# Parallel Flash Erase/Program Sequencer

This block runs the command protocol of a byte-wide parallel NOR flash bank on behalf of a requester. An erase request issues the unlock-and-erase command string. A program request pulls the bank image one byte at a time over a ready/valid stream and issues an unlock-and-program string for each byte. After each command string the sequencer polls the bank base with pairs of reads until the two reads of a pair agree. This is how the device shows that its internal operation has finished.

When the operation has finished, the sequencer writes a return-to-read command and reads back every byte of the bank. An erased bank must read all ones. A programmed bank must match the bytes that were streamed in, and the sequencer keeps a local copy of them for this check. The requester sees a busy level and one of three single-cycle result pulses: done, timeout or verify-failure. Every flash write uses a write strobe of programmable length and is followed by a settling gap. That gap is derived from the clock frequency.

Top module: `flash_seq`

## Requirements
- R1: While reset is asserted and after it is released, busy_o, src_ready_o, fl_we_o, fl_oe_o, done_o, timeout_o and vfail_o are all low until a request arrives.
- R2: Every command string begins with two unlock writes: data 0xAA at offset 0x555, then data 0x55 at offset 0x2AA.
- R3: An erase continues after the unlock pair with 0x80 at 0x555, 0xAA at 0x555, 0x55 at 0x2AA and 0x30 at offset 0 (bank base).
- R4: A program operation covers all BANK_BYTES bytes in ascending address order. For each byte it takes one byte from the source stream (transfer when src_ready_o and src_valid_i are both high), then writes the unlock pair, 0xA0 at 0x555 and the byte at its own offset.
- R5: After each erase or program string, the sequencer reads offset 0 twice per attempt. The operation is complete on the first attempt whose two reads return equal values.
- R6: If POLL_MAX attempts all return unequal reads, timeout_o pulses and the operation ends. No return-to-read write and no verify read follow, and exactly 2*POLL_MAX reads are issued.
- R7: After an erase completes, and after the last programmed byte completes, one write of 0xF0 to offset 0 is issued before any verify read.
- R8: Verify reads every offset from 0 upward. The expected value is 0xFF after an erase and the streamed byte after a program. The first mismatch pulses vfail_o and ends the operation. If there is no mismatch, done_o pulses.
- R9: Each write holds fl_we_o high for exactly STROBE_CYC cycles, with address and data stable. At least SETTLE_CYC = ceil(CLK_MHZ*SETTLE_NS/1000) cycles with both strobes low follow before the next strobe. fl_we_o and fl_oe_o are never high together.
- R10: busy_o rises in the cycle after an accepted request and stays high until the result pulse. The result pulse is one cycle long and coincides with busy_o low. Requests are ignored while busy, and erase wins when both requests arrive together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| erase_req_i | input | 1 | Start an erase (sampled when idle) |
| prog_req_i | input | 1 | Start a program operation (sampled when idle) |
| src_valid_i | input | 1 | Source byte valid |
| src_data_i | input | 8 | Source byte |
| src_ready_o | output | 1 | Sequencer accepts a source byte |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse: operation completed and verified |
| timeout_o | output | 1 | One-cycle pulse: completion never seen |
| vfail_o | output | 1 | One-cycle pulse: read-back mismatch |
| fl_addr_o | output | ADDR_W | Flash byte address |
| fl_wdata_o | output | 8 | Flash write data |
| fl_rdata_i | input | 8 | Flash read data |
| fl_we_o | output | 1 | Flash write strobe, active high |
| fl_oe_o | output | 1 | Flash read strobe, active high |

## Verification
A wrong step counter or wrong opcode selection shows up at the very next flash write as an address/data pair that differs from the expected command string. The write scoreboard catches it within one strobe. A poll counter that is off by one changes the number of read strobes before timeout_o, and the bench counts these strobes exactly. A lost or corrupted copy of the source bytes makes verify fail at the first affected offset, so a clean program run reports vfail_o instead of done_o. A shortened settle or strobe counter is visible on the strobe waveform at the first write of any operation.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  localparam logic [2:0] ERASE_LAST = 3'd5;
  localparam logic [2:0] PROG_LAST  = 3'd3;

  typedef enum logic [3:0] {
    S_IDLE, S_FETCH, S_CMD, S_CMD_W, S_POLL1, S_POLL1_W,
    S_POLL2, S_POLL2_W, S_RST, S_RST_W, S_VER, S_VER_W
  } seq_st_e;

  typedef struct packed {
    logic [10:0] off;
    logic [7:0]  dat;
    logic        at_tgt;  // address comes from byte index, not off
  } cmd_t;

  function automatic cmd_t cmd_step(input logic prog, input logic [2:0] step,
                                    input logic [7:0] pdata);
    cmd_t c;
    c = '{off: 11'h000, dat: 8'h00, at_tgt: 1'b0};
    unique case (step)
      3'd0: c = '{off: 11'h555, dat: 8'hAA, at_tgt: 1'b0};
      3'd1: c = '{off: 11'h2AA, dat: 8'h55, at_tgt: 1'b0};
      3'd2: c = '{off: 11'h555, dat: prog ? 8'hA0 : 8'h80, at_tgt: 1'b0};
      3'd3: c = prog ? '{off: 11'h000, dat: pdata, at_tgt: 1'b1}
                     : '{off: 11'h555, dat: 8'hAA, at_tgt: 1'b0};
      3'd4: c = '{off: 11'h2AA, dat: 8'h55, at_tgt: 1'b0};
      3'd5: c = '{off: 11'h000, dat: 8'h30, at_tgt: 1'b0};
      default: c = '{off: 11'h000, dat: 8'h00, at_tgt: 1'b0};
    endcase
    return c;
  endfunction

endpackage

// File: rtl/flash_bus.sv
module flash_bus #(
  parameter int ADDR_W     = 11,
  parameter int STROBE_CYC = 4,
  parameter int SETTLE_CYC = 100,
  parameter int READ_CYC   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic              ack_o,
  output logic [7:0]        rdata_o,
  output logic [ADDR_W-1:0] fl_addr_o,
  output logic [7:0]        fl_wdata_o,
  input  logic [7:0]        fl_rdata_i,
  output logic              fl_we_o,
  output logic              fl_oe_o
);
  localparam int M1   = (STROBE_CYC > SETTLE_CYC) ? STROBE_CYC : SETTLE_CYC;
  localparam int MAXC = (M1 > READ_CYC) ? M1 : READ_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  typedef enum logic [1:0] {B_IDLE, B_STROBE, B_SETTLE, B_READ} bus_st_e;

  bus_st_e           st_q;
  logic [CW-1:0]     cnt_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        wd_q, rd_q;
  logic              we_q, oe_q, ack_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= B_IDLE; cnt_q <= '0; addr_q <= '0; wd_q <= '0; rd_q <= '0;
      we_q <= 1'b0; oe_q <= 1'b0; ack_q <= 1'b0;
    end else begin
      ack_q <= 1'b0;
      unique case (st_q)
        B_IDLE: if (start_i) begin
          addr_q <= addr_i;
          if (wr_i) begin
            wd_q  <= wdata_i;
            we_q  <= 1'b1;
            cnt_q <= CW'(STROBE_CYC - 1);
            st_q  <= B_STROBE;
          end else begin
            oe_q  <= 1'b1;
            cnt_q <= CW'(READ_CYC - 1);
            st_q  <= B_READ;
          end
        end
        B_STROBE: if (cnt_q == '0) begin
          we_q  <= 1'b0;
          cnt_q <= CW'(SETTLE_CYC - 1);
          st_q  <= B_SETTLE;
        end else cnt_q <= cnt_q - 1'b1;
        B_SETTLE: if (cnt_q == '0) begin
          ack_q <= 1'b1;
          st_q  <= B_IDLE;
        end else cnt_q <= cnt_q - 1'b1;
        B_READ: if (cnt_q == '0) begin
          rd_q  <= fl_rdata_i;
          oe_q  <= 1'b0;
          ack_q <= 1'b1;
          st_q  <= B_IDLE;
        end else cnt_q <= cnt_q - 1'b1;
        default: st_q <= B_IDLE;
      endcase
    end
  end

  assign ack_o      = ack_q;
  assign rdata_o    = rd_q;
  assign fl_addr_o  = addr_q;
  assign fl_wdata_o = wd_q;
  assign fl_we_o    = we_q;
  assign fl_oe_o    = oe_q;
endmodule

// File: rtl/byte_store.sv
module byte_store #(
  parameter int DEPTH = 16,
  parameter int IW    = 4
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [IW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [IW-1:0] raddr_i,
  output logic [7:0]    rdata_o
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/flash_seq.sv
module flash_seq
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W     = 11,
  parameter int BANK_BYTES = 16,
  parameter int CLK_MHZ    = 100,
  parameter int SETTLE_NS  = 1000,
  parameter int STROBE_CYC = 4,
  parameter int READ_CYC   = 2,
  parameter int POLL_MAX   = 1000000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              erase_req_i,
  input  logic              prog_req_i,
  input  logic              src_valid_i,
  input  logic [7:0]        src_data_i,
  output logic              src_ready_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              timeout_o,
  output logic              vfail_o,
  output logic [ADDR_W-1:0] fl_addr_o,
  output logic [7:0]        fl_wdata_o,
  input  logic [7:0]        fl_rdata_i,
  output logic              fl_we_o,
  output logic              fl_oe_o
);
  localparam int SETTLE_RAW = (CLK_MHZ * SETTLE_NS + 999) / 1000;
  localparam int SETTLE_CYC = (SETTLE_RAW < 1) ? 1 : SETTLE_RAW;
  localparam int IW         = $clog2(BANK_BYTES);
  localparam int PW         = $clog2(POLL_MAX + 1);

  seq_st_e       st_q;
  logic          prog_q, done_q, tmo_q, vf_q;
  logic [2:0]    step_q;
  logic [IW-1:0] idx_q;
  logic [PW-1:0] poll_q;
  logic [7:0]    first_q, byte_q;

  logic              bus_start, bus_wr, bus_ack;
  logic [ADDR_W-1:0] bus_addr;
  logic [7:0]        bus_wdata, bus_rdata, buf_rdata, ver_exp;
  logic              last_byte, take_byte;
  cmd_t              cmd;

  assign cmd       = cmd_step(prog_q, step_q, byte_q);
  assign last_byte = (idx_q == IW'(BANK_BYTES - 1));
  assign take_byte = (st_q == S_FETCH) && src_valid_i;
  assign ver_exp   = prog_q ? buf_rdata : 8'hFF;

  always_comb begin
    bus_start = 1'b0;
    bus_wr    = 1'b0;
    bus_addr  = '0;
    bus_wdata = '0;
    unique case (st_q)
      S_CMD: begin
        bus_start = 1'b1;
        bus_wr    = 1'b1;
        bus_addr  = cmd.at_tgt ? ADDR_W'(idx_q) : ADDR_W'(cmd.off);
        bus_wdata = cmd.dat;
      end
      S_POLL1, S_POLL2: bus_start = 1'b1;
      S_RST: begin
        bus_start = 1'b1;
        bus_wr    = 1'b1;
        bus_wdata = 8'hF0;
      end
      S_VER: begin
        bus_start = 1'b1;
        bus_addr  = ADDR_W'(idx_q);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= S_IDLE; prog_q <= 1'b0; step_q <= '0; idx_q <= '0; poll_q <= '0;
      first_q <= '0; byte_q <= '0; done_q <= 1'b0; tmo_q <= 1'b0; vf_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      tmo_q  <= 1'b0;
      vf_q   <= 1'b0;
      unique case (st_q)
        S_IDLE: begin
          idx_q  <= '0;
          step_q <= '0;
          if (erase_req_i) begin
            prog_q <= 1'b0;
            st_q   <= S_CMD;
          end else if (prog_req_i) begin
            prog_q <= 1'b1;
            st_q   <= S_FETCH;
          end
        end
        S_FETCH: if (src_valid_i) begin
          byte_q <= src_data_i;
          step_q <= '0;
          st_q   <= S_CMD;
        end
        S_CMD: st_q <= S_CMD_W;
        S_CMD_W: if (bus_ack) begin
          if (step_q == (prog_q ? PROG_LAST : ERASE_LAST)) begin
            poll_q <= '0;
            st_q   <= S_POLL1;
          end else begin
            step_q <= step_q + 3'd1;
            st_q   <= S_CMD;
          end
        end
        S_POLL1: st_q <= S_POLL1_W;
        S_POLL1_W: if (bus_ack) begin
          first_q <= bus_rdata;
          st_q    <= S_POLL2;
        end
        S_POLL2: st_q <= S_POLL2_W;
        S_POLL2_W: if (bus_ack) begin
          if (bus_rdata == first_q) begin
            if (prog_q && !last_byte) begin
              idx_q <= idx_q + 1'b1;
              st_q  <= S_FETCH;
            end else st_q <= S_RST;
          end else if (poll_q == PW'(POLL_MAX - 1)) begin
            tmo_q <= 1'b1;
            st_q  <= S_IDLE;
          end else begin
            poll_q <= poll_q + 1'b1;
            st_q   <= S_POLL1;
          end
        end
        S_RST: st_q <= S_RST_W;
        S_RST_W: if (bus_ack) begin
          idx_q <= '0;
          st_q  <= S_VER;
        end
        S_VER: st_q <= S_VER_W;
        S_VER_W: if (bus_ack) begin
          if (bus_rdata != ver_exp) begin
            vf_q <= 1'b1;
            st_q <= S_IDLE;
          end else if (last_byte) begin
            done_q <= 1'b1;
            st_q   <= S_IDLE;
          end else begin
            idx_q <= idx_q + 1'b1;
            st_q  <= S_VER;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  byte_store #(.DEPTH(BANK_BYTES), .IW(IW)) u_store (
    .clk_i   (clk_i),
    .we_i    (take_byte),
    .waddr_i (idx_q),
    .wdata_i (src_data_i),
    .raddr_i (idx_q),
    .rdata_o (buf_rdata)
  );

  flash_bus #(
    .ADDR_W(ADDR_W), .STROBE_CYC(STROBE_CYC),
    .SETTLE_CYC(SETTLE_CYC), .READ_CYC(READ_CYC)
  ) u_bus (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (bus_start),
    .wr_i       (bus_wr),
    .addr_i     (bus_addr),
    .wdata_i    (bus_wdata),
    .ack_o      (bus_ack),
    .rdata_o    (bus_rdata),
    .fl_addr_o  (fl_addr_o),
    .fl_wdata_o (fl_wdata_o),
    .fl_rdata_i (fl_rdata_i),
    .fl_we_o    (fl_we_o),
    .fl_oe_o    (fl_oe_o)
  );

  assign src_ready_o = (st_q == S_FETCH);
  assign busy_o      = (st_q != S_IDLE);
  assign done_o      = done_q;
  assign timeout_o   = tmo_q;
  assign vfail_o     = vf_q;
endmodule

// File: rtl/flash_seq_chk.sv
module flash_seq_chk #(
  parameter int ADDR_W    = 11,
  parameter int CLK_MHZ   = 100,
  parameter int SETTLE_NS = 1000
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              src_ready_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              timeout_o,
  input logic              vfail_o,
  input logic [ADDR_W-1:0] fl_addr_o,
  input logic [7:0]        fl_wdata_o,
  input logic              fl_we_o,
  input logic              fl_oe_o
);
  localparam int SETTLE_RAW = (CLK_MHZ * SETTLE_NS + 999) / 1000;
  localparam int SETTLE_CYC = (SETTLE_RAW < 1) ? 1 : SETTLE_RAW;
  localparam int GW         = $clog2(SETTLE_CYC + 2);

  logic [GW-1:0] gap_q;
  logic          after_wr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q      <= '0;
      after_wr_q <= 1'b0;
    end else if (fl_we_o) begin
      gap_q      <= '0;
      after_wr_q <= 1'b1;
    end else if (fl_oe_o) begin
      after_wr_q <= 1'b0;
    end else if (gap_q != GW'(SETTLE_CYC)) begin
      gap_q <= gap_q + 1'b1;
    end
  end

  // R9
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fl_we_o && fl_oe_o));

  // R9
  wr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fl_we_o && $past(fl_we_o)) |-> ($stable(fl_addr_o) && $stable(fl_wdata_o)));

  // R9
  settle_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($rose(fl_we_o) || $rose(fl_oe_o)) && after_wr_q) |-> (gap_q >= GW'(SETTLE_CYC)));

  // R10
  result_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({done_o, timeout_o, vfail_o}));

  // R10
  result_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || timeout_o || vfail_o) |-> !busy_o);

  // R10
  busy_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (done_o || timeout_o || vfail_o));

  // R4
  ready_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_ready_o |-> (busy_o && !fl_we_o && !fl_oe_o));
endmodule

bind flash_seq flash_seq_chk #(
  .ADDR_W(ADDR_W), .CLK_MHZ(CLK_MHZ), .SETTLE_NS(SETTLE_NS)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .src_ready_o (src_ready_o),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .timeout_o   (timeout_o),
  .vfail_o     (vfail_o),
  .fl_addr_o   (fl_addr_o),
  .fl_wdata_o  (fl_wdata_o),
  .fl_we_o     (fl_we_o),
  .fl_oe_o     (fl_oe_o)
);

// File: tb/flash_seq_bench.sv
module flash_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW      = 11;
  localparam int BANK    = 8;
  localparam int MHZ     = 10;
  localparam int SNS     = 1000;
  localparam int STROBE  = 2;
  localparam int RDC     = 2;
  localparam int PMAX    = 6;
  localparam int SETTLE  = (MHZ * SNS + 999) / 1000;
  localparam int BUSY_RD = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic erase_req = 1'b0, prog_req = 1'b0, src_valid = 1'b0;
  logic [7:0] src_data = 8'h00;
  logic src_ready, busy, done, tmo, vfail, fl_we, fl_oe;
  logic [AW-1:0] fl_addr;
  logic [7:0] fl_wdata, fl_rdata;

  always #(CLK_PERIOD / 2) clk = ~clk;

  flash_seq #(
    .ADDR_W(AW), .BANK_BYTES(BANK), .CLK_MHZ(MHZ), .SETTLE_NS(SNS),
    .STROBE_CYC(STROBE), .READ_CYC(RDC), .POLL_MAX(PMAX)
  ) u_flash_seq (
    .clk_i(clk), .rst_ni(rst_n), .erase_req_i(erase_req), .prog_req_i(prog_req),
    .src_valid_i(src_valid), .src_data_i(src_data), .src_ready_o(src_ready),
    .busy_o(busy), .done_o(done), .timeout_o(tmo), .vfail_o(vfail),
    .fl_addr_o(fl_addr), .fl_wdata_o(fl_wdata), .fl_rdata_i(fl_rdata),
    .fl_we_o(fl_we), .fl_oe_o(fl_oe)
  );

  // behavioural flash model
  logic [7:0] mem [BANK];
  int  m_ucnt = 0, m_busy = 0;
  bit  m_tog = 0, m_stuck = 0, m_efail = 0, m_pfail = 0, we_p = 0, oe_p = 0;

  assign fl_rdata = (m_busy > 0) ? (m_tog ? 8'h40 : 8'h00)
                  : ((int'(fl_addr) < BANK) ? mem[fl_addr[2:0]] : 8'hFF);

  always @(posedge clk) begin
    we_p <= fl_we;
    oe_p <= fl_oe;
    if (oe_p && !fl_oe && m_busy > 0) begin
      if (!m_stuck) m_busy <= m_busy - 1;
      m_tog <= !m_tog;
    end
    if (we_p && !fl_we && m_busy == 0) begin
      if (fl_wdata == 8'hF0) m_ucnt <= 0;
      else case (m_ucnt)
        0: m_ucnt <= (fl_addr == 11'h555 && fl_wdata == 8'hAA) ? 1 : 0;
        1: m_ucnt <= (fl_addr == 11'h2AA && fl_wdata == 8'h55) ? 2 : 0;
        2: m_ucnt <= (fl_wdata == 8'hA0) ? 10 : (fl_wdata == 8'h80) ? 3 : 0;
        3: m_ucnt <= (fl_wdata == 8'hAA) ? 4 : 0;
        4: m_ucnt <= (fl_wdata == 8'h55) ? 5 : 0;
        5: begin
          m_ucnt <= 0;
          if (fl_wdata == 8'h30) begin
            for (int i = 0; i < BANK; i++) mem[i] <= 8'hFF;
            if (m_efail) mem[3] <= 8'h7F;
            m_busy <= BUSY_RD;
          end
        end
        10: begin
          m_ucnt <= 0;
          if (int'(fl_addr) < BANK)
            mem[fl_addr[2:0]] <= mem[fl_addr[2:0]] & fl_wdata &
                                 ((m_pfail && fl_addr == 11'd5) ? 8'hFE : 8'hFF);
          m_busy <= BUSY_RD;
        end
        default: m_ucnt <= 0;
      endcase
    end
  end

  // scoreboard
  int nvec = 0, nbad = 0, res_cnt = 0, oe_rises = 0;
  bit finished = 0;
  logic [18:0] exp_wr [$];
  string       exp_tag [$];
  int          exp_res [$];

  task automatic chk(input bit ok, input string msg);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s", msg);
    end
  endtask

  task automatic push_wr(input logic [10:0] a, input logic [7:0] d, input string tag);
    exp_wr.push_back({a, d});
    exp_tag.push_back(tag);
  endtask

  task automatic exp_unlock();
    push_wr(11'h555, 8'hAA, "R2");
    push_wr(11'h2AA, 8'h55, "R2");
  endtask

  task automatic exp_erase(input bit with_rst);
    exp_unlock();
    push_wr(11'h555, 8'h80, "R3");
    push_wr(11'h555, 8'hAA, "R3");
    push_wr(11'h2AA, 8'h55, "R3");
    push_wr(11'h000, 8'h30, "R3");
    if (with_rst) push_wr(11'h000, 8'hF0, "R7");
  endtask

  task automatic exp_prog(input logic [7:0] p [BANK]);
    for (int i = 0; i < BANK; i++) begin
      exp_unlock();
      push_wr(11'h555, 8'hA0, "R4");
      push_wr(11'(i), p[i], "R4");
    end
    push_wr(11'h000, 8'hF0, "R7");
  endtask

  // write/strobe monitor
  bit wprev = 0, oprev = 0, aw = 0;
  int wlen = 0, gap = 0;
  always @(negedge clk) if (rst_n) begin
    if (((fl_we && !wprev) || (fl_oe && !oprev)) && aw) begin
      chk(gap >= SETTLE, $sformatf("R9 settle gap=%0d exp>=%0d", gap, SETTLE));
      aw = 0;
    end
    if (fl_oe && !oprev) oe_rises++;
    if (fl_we) wlen++;
    if (wprev && !fl_we) begin
      chk(wlen == STROBE, $sformatf("R9 strobe len=%0d exp=%0d", wlen, STROBE));
      if (exp_wr.size() == 0)
        chk(0, $sformatf("R10 unexpected write %h/%h exp none", fl_addr, fl_wdata));
      else begin
        logic [18:0] e;
        string t;
        e = exp_wr.pop_front();
        t = exp_tag.pop_front();
        chk({fl_addr, fl_wdata} == e,
            $sformatf("%s write %h/%h exp %h/%h", t, fl_addr, fl_wdata, e[18:8], e[7:0]));
      end
      wlen = 0; gap = 1; aw = 1;
    end else if (!fl_we && !fl_oe) gap++;
    wprev = fl_we;
    oprev = fl_oe;
  end

  // result monitor
  always @(negedge clk) if (rst_n && (done || tmo || vfail)) begin
    int got, e;
    got = done ? 1 : tmo ? 2 : 3;
    e = (exp_res.size() > 0) ? exp_res.pop_front() : 0;
    chk(got == e, $sformatf("R8 result code=%0d exp=%0d (1 done 2 timeout 3 vfail)", got, e));
    chk(!busy, $sformatf("R10 busy=%0b at result exp=0", busy));
    res_cnt++;
  end

  task automatic start_op(input bit er, input bit pr);
    @(negedge clk);
    erase_req = er; prog_req = pr;
    @(negedge clk);
    erase_req = 0; prog_req = 0;
    chk(busy == 1'b1, $sformatf("R10 busy=%0b after request exp=1", busy));
  endtask

  task automatic feed(input logic [7:0] p [BANK], input int stall);
    for (int i = 0; i < BANK; i++) begin
      repeat (stall) @(negedge clk);
      src_valid = 1; src_data = p[i];
      forever begin
        if (src_ready) begin
          @(negedge clk);
          break;
        end
        @(negedge clk);
      end
      src_valid = 0;
    end
  endtask

  task automatic wait_res(input int n);
    while (res_cnt < n) @(negedge clk);
  endtask

  task automatic chk_sb_empty(input string tag);
    chk(exp_wr.size() == 0, $sformatf("%s pending writes=%0d exp=0", tag, exp_wr.size()));
  endtask

  task automatic chk_mem(input logic [7:0] p [BANK], input string tag);
    for (int i = 0; i < BANK; i++)
      chk(mem[i] == p[i], $sformatf("%s mem[%0d]=%h exp=%h", tag, i, mem[i], p[i]));
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "R10 watchdog expired exp=completion");
    summary();
  end

  initial begin
    logic [7:0] ff [BANK], pa [BANK], pb [BANK], pc [BANK];
    for (int i = 0; i < BANK; i++) begin
      mem[i] = 8'h00;
      ff[i] = 8'hFF;
      pa[i] = 8'(i * 8'h1D + 8'h0B);
      pb[i] = ~8'(i * 8'h33);
      pc[i] = 8'hF0 | 8'(i);
    end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({busy, src_ready, fl_we, fl_oe, done, tmo, vfail} == 7'b0,
        $sformatf("R1 in reset outputs=%b exp=0", {busy, src_ready, fl_we, fl_oe, done, tmo, vfail}));
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk({busy, src_ready, fl_we, fl_oe, done, tmo, vfail} == 7'b0,
        $sformatf("R1 after reset outputs=%b exp=0", {busy, src_ready, fl_we, fl_oe, done, tmo, vfail}));

    // R3 R5 R7 erase
    exp_erase(1); exp_res.push_back(1);
    start_op(1, 0); wait_res(1);
    chk_sb_empty("R3"); chk_mem(ff, "R3");

    // R4 program, no stalls
    exp_prog(pa); exp_res.push_back(1);
    start_op(0, 1); feed(pa, 0); wait_res(2);
    chk_sb_empty("R4"); chk_mem(pa, "R4");

    // R4 program with source stalls
    exp_erase(1); exp_res.push_back(1);
    start_op(1, 0); wait_res(3);
    exp_prog(pb); exp_res.push_back(1);
    start_op(0, 1); feed(pb, 3); wait_res(4);
    chk_sb_empty("R4"); chk_mem(pb, "R4");

    // R10 both requests: erase wins
    exp_erase(1); exp_res.push_back(1);
    start_op(1, 1); wait_res(5);
    chk_sb_empty("R10"); chk_mem(ff, "R10");

    // R10 request while busy ignored
    exp_erase(1); exp_res.push_back(1);
    start_op(1, 0);
    repeat (20) @(negedge clk);
    prog_req = 1; @(negedge clk); prog_req = 0;
    wait_res(6);
    repeat (40) @(negedge clk);
    chk(!busy && res_cnt == 6, $sformatf("R10 busy=%0b results=%0d exp 0/6", busy, res_cnt));
    chk_sb_empty("R10");

    // R6 timeout
    m_stuck = 1;
    exp_erase(0); exp_res.push_back(2);
    oe_rises = 0;
    start_op(1, 0); wait_res(7);
    chk(oe_rises == 2 * PMAX, $sformatf("R6 reads=%0d exp=%0d", oe_rises, 2 * PMAX));
    repeat (30) @(negedge clk);
    chk_sb_empty("R6");
    m_stuck = 0; m_busy = 0;

    // R8 erase verify failure
    m_efail = 1;
    exp_erase(1); exp_res.push_back(3);
    start_op(1, 0); wait_res(8);
    chk_sb_empty("R8");
    m_efail = 0;

    // R8 program verify failure
    exp_erase(1); exp_res.push_back(1);
    start_op(1, 0); wait_res(9);
    m_pfail = 1;
    exp_prog(pc); exp_res.push_back(3);
    start_op(0, 1); feed(pc, 1); wait_res(10);
    chk_sb_empty("R8");
    m_pfail = 0;

    repeat (10) @(negedge clk);
    summary();
  end
endmodule